// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block produces the clock-line level and the two mid-phase strobes for an I2C master engine, all derived from the system clock. Software programs a 12-bit main divider, a 12-bit low-phase count and a mode select. The divider reaches the block as a 10-bit lower part and a 2-bit upper part, because the two parts sit in separate control fields. The block asserts the clock line low or releases it high, and it flags the cycle in the middle of each phase where the bit shifter acts. Data changes in the middle of the low phase. The line is sampled in the middle of the high phase.

There are two modes. In symmetric mode the divider is a quarter-period count. The low phase lasts two quarters, and the high phase lasts two quarters plus a fixed 15-cycle allowance for the input filter delay. In split mode the divider gives the high phase on its own, with the same 15-cycle allowance added, and the low-phase count gives half of the low phase. This allows a duty cycle below one half, such as 40/60, which fast-mode timing needs. A run input starts and stops the generator. While it is low, the line stays released. A divider or count of zero is treated as one, so the line always keeps toggling.

Top module: `scl_timing_gen`

## Requirements
- R1: While rst_ni is low or run_i is low, scl_o is 1 and both sample_tick_o and change_tick_o are 0, whatever the divider inputs hold.
- R2: When run_i is sampled high at a clock edge from idle, scl_o is 0 from that edge on. Every run starts with a low phase whose first cycle is index 0.
- R3: In symmetric mode (split_en_i = 0) the quarter count q is {div_hi_i, div_lo_i}, so div_hi_i holds bits 11:10. The low phase lasts 2*q cycles and the high phase lasts 2*q+15 cycles.
- R4: In split mode (split_en_i = 1) the high phase lasts D+15 cycles, where D = {div_hi_i, div_lo_i}. The low phase lasts 2*L cycles, where L = low_cnt_i.
- R5: A value of zero for D (or q) or for L is used as 1. The shortest low phase is therefore 2 cycles and the shortest high phase 16 cycles.
- R6: change_tick_o is high for exactly one cycle per low phase, at cycle index floor(low_length/2) counted from 0.
- R7: sample_tick_o is high for exactly one cycle per high phase, at cycle index floor(high_length/2) counted from 0.
- R8: When run_i is sampled low, the generator returns to idle at that edge. A later start begins again with a full low phase.
- R9: In symmetric mode low_cnt_i has no effect on either phase length.
- R10: If the lengths change while a phase runs, and the phase counter has already reached the new end, the phase ends at the next clock edge.
- R11: sample_tick_o and change_tick_o are never high in the same cycle. change_tick_o is high only while scl_o is 0, and sample_tick_o only while scl_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Generator enable |
| div_lo_i | input | 10 | Main divider bits 9:0 |
| div_hi_i | input | 2 | Main divider bits 11:10 |
| low_cnt_i | input | 12 | Half low-phase count for split mode |
| split_en_i | input | 1 | 1 selects separate high and low lengths |
| scl_o | output | 1 | Clock line level, 0 = pull low |
| sample_tick_o | output | 1 | Mid-high-phase strobe |
| change_tick_o | output | 1 | Mid-low-phase strobe |

## Verification
A phase can end in the same cycle as a stop request or as a length change. The bench provokes the length case by shrinking the divider during a long high phase. The counter is then already past the new end, and the bench judges that scl_o falls on the very next edge and that the following period uses the new lengths exactly. It also drops run_i partway through a low phase and requires the line to be released one edge later, with no strobe. On restart it requires a full-length low phase. Per-period strobe counts confirm that the two strobes never coincide and that each appears once.

// File: rtl/scl_tgen_pkg.sv
`timescale 1ns/1ps
package scl_tgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_len_decode.sv
`timescale 1ns/1ps
module scl_len_decode #(
  parameter int DIV_LO_W = 10,
  parameter int DIV_HI_W = 2,
  parameter int LOW_W    = 12,
  parameter int FILT_CYC = 15,
  parameter int LEN_W    = 14
) (
  input  logic [DIV_LO_W-1:0] div_lo_i,
  input  logic [DIV_HI_W-1:0] div_hi_i,
  input  logic [LOW_W-1:0]    low_cnt_i,
  input  logic                split_en_i,
  output logic [LEN_W-1:0]    low_len_o,
  output logic [LEN_W-1:0]    high_len_o
);
  localparam int DIV_W = DIV_LO_W + DIV_HI_W;

  logic [DIV_W-1:0] div_raw, div_eff;
  logic [LOW_W-1:0] lc_eff;
  logic [LEN_W-1:0] div_x, lc_x, filt_x;

  assign div_raw = {div_hi_i, div_lo_i};
  // zero would stall the line; promote to one
  assign div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
  assign lc_eff  = (low_cnt_i == '0) ? LOW_W'(1) : low_cnt_i;
  assign div_x   = LEN_W'(div_eff);
  assign lc_x    = LEN_W'(lc_eff);
  assign filt_x  = LEN_W'(FILT_CYC);

  always_comb begin
    if (split_en_i) begin
      high_len_o = div_x + filt_x;
      low_len_o  = lc_x << 1;
    end else begin
      low_len_o  = div_x << 1;
      high_len_o = (div_x << 1) + filt_x;
    end
  end
endmodule

// File: rtl/scl_phase_ctr.sv
`timescale 1ns/1ps
module scl_phase_ctr
  import scl_tgen_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output phase_e           phase_o,
  output logic [LEN_W-1:0] cnt_o
);
  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cur_len;
  logic             at_end;

  assign cur_len = (phase_q == PH_HIGH) ? high_len_i : low_len_i;
  // >= so a shrunk length ends the phase at once
  assign at_end  = ({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, cur_len};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (at_end) begin
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + LEN_W'(1);
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && run_i) |=> (phase_q == PH_LOW && cnt_q == '0));
  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (phase_q == PH_IDLE));
  assert_shrink_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && phase_q != PH_IDLE && {1'b0, cnt_q} + (LEN_W+1)'(1) > {1'b0, cur_len})
      |=> (cnt_q == '0 && phase_q != $past(phase_q)));
endmodule

// File: rtl/scl_tick_gen.sv
`timescale 1ns/1ps
module scl_tick_gen
  import scl_tgen_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  phase_e           phase_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output logic             scl_o,
  output logic             sample_tick_o,
  output logic             change_tick_o
);
  assign scl_o         = (phase_i != PH_LOW);
  assign change_tick_o = (phase_i == PH_LOW)  && (cnt_i == (low_len_i  >> 1));
  assign sample_tick_o = (phase_i == PH_HIGH) && (cnt_i == (high_len_i >> 1));
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_tgen_pkg::*;
#(
  parameter int DIV_LO_W = 10,
  parameter int DIV_HI_W = 2,
  parameter int LOW_W    = 12,
  parameter int FILT_CYC = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [DIV_LO_W-1:0] div_lo_i,
  input  logic [DIV_HI_W-1:0] div_hi_i,
  input  logic [LOW_W-1:0]    low_cnt_i,
  input  logic                split_en_i,
  output logic                scl_o,
  output logic                sample_tick_o,
  output logic                change_tick_o
);
  localparam int DIV_W = DIV_LO_W + DIV_HI_W;
  localparam int LEN_W = ((DIV_W > LOW_W) ? DIV_W : LOW_W) + 2;

  logic [LEN_W-1:0] low_len, high_len, cnt;
  phase_e           phase;

  scl_len_decode #(
    .DIV_LO_W(DIV_LO_W), .DIV_HI_W(DIV_HI_W), .LOW_W(LOW_W),
    .FILT_CYC(FILT_CYC), .LEN_W(LEN_W)
  ) u_dec (
    .div_lo_i  (div_lo_i),
    .div_hi_i  (div_hi_i),
    .low_cnt_i (low_cnt_i),
    .split_en_i(split_en_i),
    .low_len_o (low_len),
    .high_len_o(high_len)
  );

  scl_phase_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .low_len_i (low_len),
    .high_len_i(high_len),
    .phase_o   (phase),
    .cnt_o     (cnt)
  );

  scl_tick_gen #(.LEN_W(LEN_W)) u_tick (
    .phase_i      (phase),
    .cnt_i        (cnt),
    .low_len_i    (low_len),
    .high_len_i   (high_len),
    .scl_o        (scl_o),
    .sample_tick_o(sample_tick_o),
    .change_tick_o(change_tick_o)
  );

  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_o && !sample_tick_o && !change_tick_o));
  assert_min_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_len >= LEN_W'(2)) && (high_len >= LEN_W'(FILT_CYC + 1)));
  assert_change_in_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_tick_o |-> !scl_o);
  assert_sample_in_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |-> scl_o);
  assert_ticks_apart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_tick_o && change_tick_o));
endmodule

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [11:0] div = '0;
  logic [11:0] lc = '0;
  logic        split = 1'b0;
  logic        scl, stick, ctick;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  scl_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .div_lo_i(div[9:0]), .div_hi_i(div[11:10]),
    .low_cnt_i(lc), .split_en_i(split),
    .scl_o(scl), .sample_tick_o(stick), .change_tick_o(ctick)
  );

  typedef struct packed {
    logic        sp;
    logic [11:0] dv;
    logic [11:0] lw;
    logic [15:0] exp_lo;
    logic [15:0] exp_hi;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'd3,    12'd0,  16'd6,    16'd21},   // R3
    '{1'b0, 12'h401,  12'd0,  16'd2050, 16'd2065}, // R3 upper divider bits
    '{1'b0, 12'd0,    12'd9,  16'd2,    16'd17},   // R5 R9
    '{1'b1, 12'd10,   12'd12, 16'd24,   16'd25},   // R4
    '{1'b1, 12'd0,    12'd0,  16'd2,    16'd16},   // R5
    '{1'b1, 12'd1,    12'd5,  16'd10,   16'd16}    // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at the negedge of the first low cycle; returns at the negedge of the next low
  task automatic measure(output int lo, output int hi, output int ct, output int st,
                         output int nct, output int nst);
    lo = 0; hi = 0; ct = -1; st = -1; nct = 0; nst = 0;
    while (scl == 1'b0) begin
      if (ctick) begin ct = lo; nct++; end
      if (stick) nst++;
      lo++;
      @(negedge clk);
    end
    while (scl == 1'b1) begin
      if (stick) begin st = hi; nst++; end
      if (ctick) nct++;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    summary();
  end

  initial begin
    int lo, hi, ct, st, nct, nst;
    // R1: reset state
    div = 12'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset scl", int'(scl), 1);
    chk("R1 reset ticks", int'(stick | ctick), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle scl", int'(scl), 1);
    chk("R1 idle ticks", int'(stick | ctick), 0);

    for (int i = 0; i < NV; i++) begin
      run = 1'b0;
      split = VECS[i].sp; div = VECS[i].dv; lc = VECS[i].lw;
      repeat (3) @(negedge clk);
      chk("R1 idle before run", int'(scl), 1);
      run = 1'b1;
      @(negedge clk);
      chk("R2 first phase low", int'(scl), 0);
      measure(lo, hi, ct, st, nct, nst);
      chk("R3/R4 low length", lo, int'(VECS[i].exp_lo));
      chk("R3/R4 high length", hi, int'(VECS[i].exp_hi));
      chk("R6 change tick index", ct, int'(VECS[i].exp_lo) / 2);
      chk("R7 sample tick index", st, int'(VECS[i].exp_hi) / 2);
      chk("R6 R11 change ticks per period", nct, 1);
      chk("R7 R11 sample ticks per period", nst, 1);
    end

    // R9: low count ignored in symmetric mode (same divider, different lc)
    run = 1'b0; split = 1'b0; div = 12'd3; lc = 12'd4000;
    repeat (3) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    measure(lo, hi, ct, st, nct, nst);
    chk("R9 low length with lc set", lo, 6);
    chk("R9 high length with lc set", hi, 21);

    // R8: stop mid low phase, then restart
    repeat (2) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R8 released after stop", int'(scl), 1);
    chk("R8 no ticks after stop", int'(stick | ctick), 0);
    repeat (5) @(negedge clk);
    chk("R8 R1 stays released", int'(scl), 1);
    run = 1'b1;
    @(negedge clk);
    chk("R8 restart low", int'(scl), 0);
    measure(lo, hi, ct, st, nct, nst);
    chk("R8 full low after restart", lo, 6);
    chk("R8 full high after restart", hi, 21);

    // R10: shrink divider while high phase counter is past the new end
    run = 1'b0; div = 12'd100; lc = '0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    while (scl == 1'b0) @(negedge clk);
    repeat (150) @(negedge clk);
    chk("R10 still high before shrink", int'(scl), 1);
    div = 12'd3;
    @(negedge clk);
    chk("R10 phase ends next edge", int'(scl), 0);
    measure(lo, hi, ct, st, nct, nst);
    chk("R10 new low length", lo, 6);
    chk("R10 new high length", hi, 21);

    run = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule